// File: doc/BRIEF.md
# Display Register Commit Controller

This block decides when a display engine starts, stops and picks up fresh configuration. Software reaches it through a word-addressed register-write port and a register-read port. The bank holds a control word, a mode word, an interrupt unit and a parameterised set of configuration words. The configuration words drive the engine through the `active_cfg` output.

The engine has two output modes, and each has its own commit rule. In continuous video mode, configuration writes land in staging copies. A software update request is held until the next frame boundary, where the staged words are copied to the active set and an update-done event is raised. In command mode the engine has no shadow registers. Configuration becomes visible only at the moment the run bit goes from 0 to 1. A frame starts at that moment, and the frame ends when the engine reports that it has been sent.

Completion and engine events (done, tearing effect, underflow, update-done and vsync) are collected in a sticky status register. The status register is masked by an enable register and cleared by writing ones to a clear register. The masked status is ORed into one interrupt line.

Top module: `disp_commit_ctrl`

## Requirements
- R1: After reset, `running`, `frame_start`, `irq`, `active_cfg` and every status bit are 0, and the mode is video (mode word bit 0 = 0).
- R2: A write of 1 to control bit 0 (run) while stopped sets `running` at that clock edge. At the same edge it pulses `frame_start` for exactly one cycle and loads every staged configuration word into `active_cfg`, in both modes.
- R3: In video mode, writes to configuration words (word address 8 + n) while running leave `active_cfg` unchanged until an update is committed.
- R4: In video mode, writing 1 to control bit 2 (update) while running marks an update as pending; control readback bit 2 stays 1 while it is pending. At the next `frame_end` the staged words are copied to `active_cfg`, status bit 4 (update-done) is set, and the pending flag clears.
- R5: If an update write and `frame_end` fall in the same cycle, the copy happens at that edge and update-done fires once. A later `frame_end` does not set it again.
- R6: In video mode, an update write while stopped copies the staged words at that edge and sets status bit 4.
- R7: In command mode, configuration writes and update writes do not change `active_cfg` and do not set status bit 4. The staged words reach `active_cfg` only when run rises.
- R8: In video mode, writing 1 to control bit 1 (stop) while running keeps `running` at 1, and control readback bit 1 shows the request. At the next `frame_end`, `running` clears and status bit 0 (done) is set.
- R9: In command mode, `frame_end` while running clears `running` and sets status bit 0. A stop write has no effect on `running`.
- R10: Pulses on `te_evt`, `underflow_evt` and `vsync_evt` set status bits 1, 2 and 5. Status bits stay set whatever the enable register (word 2) holds. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R11: Writing ones to the clear register (word 3) clears the matching status bits, and 0xFF clears all of them. An event arriving in the same cycle as its clear leaves the bit set.
- R12: `frame_end` while stopped changes nothing. A run write while already running produces no `frame_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, RD_LAT cycles after `rd_addr` |
| frame_end | input | 1 | Frame boundary (video) or frame sent (command) |
| te_evt | input | 1 | Tearing-effect event pulse |
| underflow_evt | input | 1 | Pixel underflow event pulse |
| vsync_evt | input | 1 | Vsync event pulse |
| running | output | 1 | Engine run state |
| frame_start | output | 1 | One-cycle pulse when run rises |
| active_cfg | output | NUM_CFG*DATA_W | Active configuration words, word 0 in the low bits |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with DATA_W = 16, NUM_CFG = 3, ADDR_W = 5 and RD_LAT = 1. Three configuration words are enough to tell a whole-set copy from a single-word write. The narrow data path still covers the 0xFF clear-all pattern. The registered read variant lets the bench read the pending bits of the control word back one cycle after addressing it. The bench also drives an update write and a frame boundary in the same cycle, so that case is covered.

// File: rtl/disp_commit_pkg.sv
package disp_commit_pkg;
   // word addresses of the register bank
   localparam int A_CTRL    = 0;
   localparam int A_MODE    = 1;
   localparam int A_IRQ_EN  = 2;
   localparam int A_IRQ_CLR = 3;
   localparam int A_IRQ_STS = 4;
   localparam int A_CFG0    = 8;

   // control word bits
   localparam int CB_RUN  = 0;
   localparam int CB_STOP = 1;
   localparam int CB_UPD  = 2;

   // interrupt bit positions
   localparam int IB_DONE  = 0;
   localparam int IB_TE    = 1;
   localparam int IB_ERR   = 2;
   localparam int IB_UPD   = 4;
   localparam int IB_VSYNC = 5;
   localparam int IRQ_W    = 6;

   typedef struct packed {
      logic vsync;
      logic upd;
      logic err;
      logic te;
      logic done;
   } irq_evt_t;
endpackage

// File: rtl/dcc_sequencer.sv
module dcc_sequencer (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic run_bit,
   input  logic stop_bit,
   input  logic upd_bit,
   input  logic cmd_mode,
   input  logic frame_end,
   output logic running,
   output logic frame_start,
   output logic stop_pend,
   output logic upd_pend,
   output logic load_active,
   output logic done_evt,
   output logic upd_done_evt
);
   logic start, boundary, upd_now, stop_now, copy_upd, stop_hit, cmd_hit, end_frame;

   always_comb begin
      start     = ctrl_wr & run_bit & ~running;
      boundary  = frame_end & running;
      upd_now   = ctrl_wr & upd_bit & ~cmd_mode;
      stop_now  = ctrl_wr & stop_bit & running & ~cmd_mode;
      // video: commit at boundary when pending, or at once when stopped
      copy_upd  = ~cmd_mode & ((boundary & (upd_pend | upd_now)) | (~running & upd_now));
      stop_hit  = ~cmd_mode & boundary & (stop_pend | stop_now);
      cmd_hit   = cmd_mode & boundary;
      end_frame = stop_hit | cmd_hit;
      load_active  = start | copy_upd;
      done_evt     = end_frame;
      upd_done_evt = copy_upd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         frame_start <= 1'b0;
         stop_pend   <= 1'b0;
         upd_pend    <= 1'b0;
      end else begin
         frame_start <= start;
         if (start)          running <= 1'b1;
         else if (end_frame) running <= 1'b0;
         stop_pend <= running & ~cmd_mode & (stop_pend | stop_now) & ~stop_hit;
         upd_pend  <= running & ~cmd_mode & (upd_pend | upd_now) & ~boundary;
      end
   end
endmodule

// File: rtl/dcc_cfg_bank.sv
module dcc_cfg_bank #(
   parameter int DATA_W  = 32,
   parameter int NUM_CFG = 4,
   parameter int ADDR_W  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      load_active,
   output logic [NUM_CFG*DATA_W-1:0] active_flat
);
   import disp_commit_pkg::*;

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(A_CFG0 + i);
      logic [DATA_W-1:0] staged_q, active_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            staged_q <= '0;
            active_q <= '0;
         end else begin
            if (wr_en && wr_addr == SLOT_ADDR) staged_q <= wr_data;
            if (load_active)                    active_q <= staged_q;
         end
      end

      assign active_flat[i*DATA_W +: DATA_W] = active_q;
   end
endmodule

// File: rtl/dcc_irq_unit.sv
module dcc_irq_unit (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 en_wr,
   input  logic                                 clr_wr,
   input  logic [disp_commit_pkg::IRQ_W-1:0]    wr_bits,
   input  disp_commit_pkg::irq_evt_t            evt,
   output logic [disp_commit_pkg::IRQ_W-1:0]    en_q,
   output logic [disp_commit_pkg::IRQ_W-1:0]    sts_q,
   output logic                                 irq
);
   import disp_commit_pkg::*;

   logic [IRQ_W-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec           = '0;
      set_vec[IB_DONE]  = evt.done;
      set_vec[IB_TE]    = evt.te;
      set_vec[IB_ERR]   = evt.err;
      set_vec[IB_UPD]   = evt.upd;
      set_vec[IB_VSYNC] = evt.vsync;
      clr_vec = clr_wr ? wr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sts_q <= '0;
      end else begin
         if (en_wr) en_q <= wr_bits;
         sts_q <= (sts_q & ~clr_vec) | set_vec;
      end
   end

   assign irq = |(sts_q & en_q);
endmodule

// File: rtl/disp_commit_ctrl.sv
module disp_commit_ctrl #(
   parameter int DATA_W  = 32,
   parameter int NUM_CFG = 4,
   parameter int ADDR_W  = 6,
   parameter int RD_LAT  = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      frame_end,
   input  logic                      te_evt,
   input  logic                      underflow_evt,
   input  logic                      vsync_evt,
   output logic                      running,
   output logic                      frame_start,
   output logic [NUM_CFG*DATA_W-1:0] active_cfg,
   output logic                      irq
);
   import disp_commit_pkg::*;

   if (DATA_W < 8)                     begin : g_bad_w   $error("DATA_W must be at least 8"); end
   if (NUM_CFG < 1)                    begin : g_bad_n   $error("NUM_CFG must be at least 1"); end
   if (A_CFG0 + NUM_CFG > 2**ADDR_W)   begin : g_bad_a   $error("ADDR_W too narrow for NUM_CFG"); end
   if (RD_LAT != 0 && RD_LAT != 1)     begin : g_bad_l   $error("RD_LAT must be 0 or 1"); end

   logic mode_q;
   logic ctrl_wr;
   logic stop_pend, upd_pend, load_active, done_evt, upd_done_evt;
   logic [IRQ_W-1:0] en_w, sts_w;
   irq_evt_t evt;

   assign ctrl_wr = wr_en && wr_addr == ADDR_W'(A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     mode_q <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(A_MODE))   mode_q <= wr_data[0];
   end

   dcc_sequencer i_seq (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
      .run_bit(wr_data[CB_RUN]), .stop_bit(wr_data[CB_STOP]), .upd_bit(wr_data[CB_UPD]),
      .cmd_mode(mode_q), .frame_end(frame_end),
      .running(running), .frame_start(frame_start),
      .stop_pend(stop_pend), .upd_pend(upd_pend), .load_active(load_active),
      .done_evt(done_evt), .upd_done_evt(upd_done_evt)
   );

   dcc_cfg_bank #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load_active(load_active), .active_flat(active_cfg)
   );

   always_comb begin
      evt.done  = done_evt;
      evt.te    = te_evt;
      evt.err   = underflow_evt;
      evt.upd   = upd_done_evt;
      evt.vsync = vsync_evt;
   end

   dcc_irq_unit i_irq (
      .clk(clk), .rst_n(rst_n),
      .en_wr(wr_en && wr_addr == ADDR_W'(A_IRQ_EN)),
      .clr_wr(wr_en && wr_addr == ADDR_W'(A_IRQ_CLR)),
      .wr_bits(wr_data[IRQ_W-1:0]), .evt(evt),
      .en_q(en_w), .sts_q(sts_w), .irq(irq)
   );

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (rd_addr == ADDR_W'(A_CTRL)) begin
         rd_val[CB_RUN]  = running;
         rd_val[CB_STOP] = stop_pend;
         rd_val[CB_UPD]  = upd_pend;
      end else if (rd_addr == ADDR_W'(A_MODE)) begin
         rd_val[0] = mode_q;
      end else if (rd_addr == ADDR_W'(A_IRQ_EN)) begin
         rd_val[IRQ_W-1:0] = en_w;
      end else if (rd_addr == ADDR_W'(A_IRQ_STS)) begin
         rd_val[IRQ_W-1:0] = sts_w;
      end
      for (int i = 0; i < NUM_CFG; i++)
         if (rd_addr == ADDR_W'(A_CFG0 + i)) rd_val = active_cfg[i*DATA_W +: DATA_W];
   end

   if (RD_LAT == 1) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_val;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_val;
   end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
   parameter int DATA_W  = 32,
   parameter int NUM_CFG = 4,
   parameter int ADDR_W  = 6
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 wr_en,
   input logic [ADDR_W-1:0]                    wr_addr,
   input logic [DATA_W-1:0]                    wr_data,
   input logic                                 frame_end,
   input logic                                 running,
   input logic                                 frame_start,
   input logic [NUM_CFG*DATA_W-1:0]            active_cfg,
   input logic [disp_commit_pkg::IRQ_W-1:0]    irq_sts
);
   import disp_commit_pkg::*;

   a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> running && !$past(running));

   a_r12_start_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> frame_start);

   a_r8_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(frame_end));

   a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_cfg) |-> $past(frame_end) || $past(wr_en));

   a_r4_upd_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_sts[IB_UPD]) |-> $past(frame_end) || !$past(running));

   a_r11_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_sts[IB_VSYNC]) |->
         $past(wr_en && wr_addr == ADDR_W'(A_IRQ_CLR) && wr_data[IB_VSYNC]));
endmodule

bind disp_commit_ctrl dcc_checker #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .frame_end(frame_end), .running(running), .frame_start(frame_start),
   .active_cfg(active_cfg), .irq_sts(sts_w)
);

// File: tb/test_disp_commit_ctrl.sv
module test_disp_commit_ctrl;
   localparam int DW = 16;
   localparam int NC = 3;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic frame_end = 1'b0, te_evt = 1'b0, underflow_evt = 1'b0, vsync_evt = 1'b0;
   logic running, frame_start, irq;
   logic [NC*DW-1:0] active_cfg;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_act [NC];
   logic [DW-1:0] rv;

   always #2 clk = ~clk;

   disp_commit_ctrl #(.DATA_W(DW), .NUM_CFG(NC), .ADDR_W(AW), .RD_LAT(1)) i_disp_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .frame_end(frame_end), .te_evt(te_evt),
      .underflow_evt(underflow_evt), .vsync_evt(vsync_evt), .running(running),
      .frame_start(frame_start), .active_cfg(active_cfg), .irq(irq)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   task automatic chk_act(string req);
      for (int i = 0; i < NC; i++)
         check(req, 64'(active_cfg[i*DW +: DW]), 64'(exp_act[i]));
   endtask

   task automatic t_reset();
      check("R1 running", 64'(running), 0);
      check("R1 frame_start", 64'(frame_start), 0);
      check("R1 irq", 64'(irq), 0);
      check("R1 active", 64'(active_cfg), 0);
      rd(4, rv); check("R1 status", 64'(rv), 0);
      rd(1, rv); check("R1 mode", 64'(rv), 0);
   endtask

   task automatic t_video_start();
      wr(8, 16'h1111); wr(9, 16'h2222);
      chk_act("R3 staged not active");
      wr(0, 16'h0001);
      exp_act[0] = 16'h1111; exp_act[1] = 16'h2222;
      check("R2 running", 64'(running), 1);
      check("R2 frame_start high", 64'(frame_start), 1);
      chk_act("R2 load on run");
      @(negedge clk);
      check("R2 frame_start one cycle", 64'(frame_start), 0);
      wr(0, 16'h0001);
      check("R12 no restart pulse", 64'(frame_start), 0);
   endtask

   task automatic t_video_update();
      wr(8, 16'h3333);
      chk_act("R3 hold while running");
      wr(0, 16'h0004);
      rd(0, rv); check("R4 pending readback", 64'(rv & 16'h4), 64'h4);
      chk_act("R4 no copy before boundary");
      pulse_frame();
      exp_act[0] = 16'h3333;
      chk_act("R4 copy at boundary");
      rd(4, rv); check("R4 update-done", 64'(rv & 16'h10), 64'h10);
      rd(0, rv); check("R4 pending cleared", 64'(rv & 16'h4), 0);
      wr(3, 16'h0010);
   endtask

   task automatic t_update_coincide();
      wr(9, 16'h4444);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(0); wr_data = 16'h0004; frame_end = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; frame_end = 1'b0;
      exp_act[1] = 16'h4444;
      chk_act("R5 copy at same edge");
      rd(4, rv); check("R5 update-done", 64'(rv & 16'h10), 64'h10);
      wr(3, 16'h0010);
      pulse_frame();
      rd(4, rv); check("R5 fires once", 64'(rv & 16'h10), 0);
      check("R5 still running", 64'(running), 1);
   endtask

   task automatic t_video_stop();
      wr(0, 16'h0002);
      check("R8 run held", 64'(running), 1);
      rd(0, rv); check("R8 stop readback", 64'(rv & 16'h2), 64'h2);
      pulse_frame();
      check("R8 stopped", 64'(running), 0);
      rd(4, rv); check("R8 done", 64'(rv & 16'h1), 64'h1);
      wr(3, 16'h00FF);
      pulse_frame();
      check("R12 idle frame_end", 64'(running), 0);
      rd(4, rv); check("R12 no status", 64'(rv), 0);
   endtask

   task automatic t_update_stopped();
      wr(10, 16'h5555);
      wr(0, 16'h0004);
      exp_act[2] = 16'h5555;
      chk_act("R6 copy while stopped");
      rd(4, rv); check("R6 update-done", 64'(rv & 16'h10), 64'h10);
      wr(3, 16'h00FF);
   endtask

   task automatic t_command();
      wr(1, 16'h0001);
      wr(8, 16'h6666);
      chk_act("R7 no direct effect");
      wr(0, 16'h0001);
      exp_act[0] = 16'h6666;
      chk_act("R7 load on run edge");
      wr(8, 16'h7777);
      wr(0, 16'h0004);
      chk_act("R7 update ignored");
      rd(4, rv); check("R7 no update-done", 64'(rv & 16'h10), 0);
      wr(0, 16'h0002);
      check("R9 stop ignored", 64'(running), 1);
      pulse_frame();
      check("R9 frame sent stops", 64'(running), 0);
      rd(4, rv); check("R9 done", 64'(rv & 16'h1), 64'h1);
      wr(3, 16'h00FF);
      wr(0, 16'h0001);
      exp_act[0] = 16'h7777;
      chk_act("R7 second run edge");
      pulse_frame();
      check("R9 second frame", 64'(running), 0);
      wr(3, 16'h00FF);
      wr(1, 16'h0000);
   endtask

   task automatic t_irq();
      wr(2, 16'h0000);
      @(negedge clk); te_evt = 1'b1; @(negedge clk); te_evt = 1'b0;
      rd(4, rv); check("R10 te sticky", 64'(rv), 64'h2);
      check("R10 masked irq", 64'(irq), 0);
      wr(2, 16'h0002);
      check("R10 irq on enable", 64'(irq), 1);
      @(negedge clk); underflow_evt = 1'b1; vsync_evt = 1'b1;
      @(negedge clk); underflow_evt = 1'b0; vsync_evt = 1'b0;
      rd(4, rv); check("R10 err and vsync", 64'(rv), 64'h26);
      wr(3, 16'h0002);
      rd(4, rv); check("R11 single clear", 64'(rv), 64'h24);
      check("R11 irq drops", 64'(irq), 0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(3); wr_data = 16'h0020; vsync_evt = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; vsync_evt = 1'b0;
      rd(4, rv); check("R11 set wins", 64'(rv), 64'h24);
      wr(3, 16'h00FF);
      rd(4, rv); check("R11 clear all", 64'(rv), 0);
      check("R11 irq idle", 64'(irq), 0);
   endtask

   initial begin
      for (int i = 0; i < NC; i++) exp_act[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_video_start();
      t_video_update();
      t_update_coincide();
      t_video_stop();
      t_update_stopped();
      t_command();
      t_irq();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule